// File: doc/BRIEF.md
# Code Fetch Address Unit

This unit forms the 16-bit program-memory addresses that an 8032-class core needs for control transfers and for table lookups in code space. The core presents the address of the current instruction, the address of the instruction that follows it, the accumulator, the data pointer, the two operand bytes and a 3-bit mode code, then pulses `start`. For the three branch modes the unit returns a jump target. For the two indexed modes it issues a one-byte read to program memory and hands the returned byte back as an accumulator write. The core itself handles instruction decode, call stacking and the memory.

Branch targets are formed in one of three ways. A relative jump adds a signed 8-bit offset to the jump's own address. A page-absolute jump keeps the top five bits of the following instruction's address and replaces the low eleven bits with the operand. A long jump takes all sixteen bits from the operands. Indexed fetches add the accumulator, as an unsigned value, to either the data pointer or the following instruction's address. Every sum wraps modulo 65536 and no flag is raised. Branch results come out of an output register one cycle after `start`.

A small controller runs the indexed read. Its states are **IDLE**, **REQ** and **RSP**. Its transitions are:

- IDLE→REQ when `start` arrives with an indexed mode.
- REQ→RSP when the memory accepts the request.
- RSP→IDLE when the returned byte is accepted.

In every other case the controller stays in its present state.

Top module: `cfa_addr_unit`

## Requirements
- R1: While `rst_n` is low, `tgt_valid`, `mem_req_valid`, `mem_rsp_ready` and `acc_we` are all low.
- R2: Mode 3'b001 (relative) yields `cur_pc` plus `op1` read as two's complement, wrapping modulo 65536 (1000h with 34h gives 1034h).
- R3: Mode 3'b010 (page-absolute) yields `{next_pc[15:11], op1[2:0], op2}` (next 4000h with operand 0500h gives 4500h).
- R4: Mode 3'b011 (long) yields `{op1, op2}`, with `op1` as bits 15:8.
- R5: Mode 3'b100 reads code at `dptr + acc` (acc unsigned, wrap modulo 65536).
- R6: Mode 3'b101 reads code at `next_pc + acc` (acc unsigned, wrap modulo 65536).
- R7: Codes 3'b000, 3'b110 and 3'b111 yield `next_pc` as the target and never raise `mem_req_valid` or `acc_we`.
- R8: For a branch or unused code accepted in IDLE, `tgt_valid` is high for exactly the one cycle after the `start` edge, with the target on `tgt_addr`.
- R9: For an indexed mode, `mem_req_valid` rises the cycle after `start` and stays high with `mem_addr` stable until the cycle after `mem_req_ready` is seen.
- R10: After the request handshake, `mem_rsp_ready` is high. In the cycle where `mem_rsp_valid` is also high, `acc_we` is high and `acc_wdata` equals `mem_rsp_data`. The unit then returns to IDLE.
- R11: A `start` that arrives while an indexed read is in progress is ignored: it produces no `tgt_valid` and no extra memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe for one address computation |
| mode | input | 3 | Address-formation code |
| cur_pc | input | 16 | Address of the current instruction |
| next_pc | input | 16 | Address of the following instruction |
| acc | input | 8 | Accumulator value (index) |
| dptr | input | 16 | Data pointer |
| op1 | input | 8 | First operand byte |
| op2 | input | 8 | Second operand byte |
| tgt_valid | output | 1 | Branch target valid |
| tgt_addr | output | 16 | Branch target |
| mem_req_valid | output | 1 | Code read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_addr | output | 16 | Code read address |
| mem_rsp_valid | input | 1 | Returned byte valid |
| mem_rsp_data | input | 8 | Returned code byte |
| mem_rsp_ready | output | 1 | Unit accepts returned byte |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 8 | Byte for the accumulator |

## Verification
If the controller were stuck outside IDLE, the next branch would produce no `tgt_valid`, and the scoreboard would still hold an item when the run drained. If it left RSP too early or too late, the accumulator write would be lost or duplicated within a few cycles of the response. A wrong fetch-address sum shows at once as a wrong returned byte, because the bench memory derives every byte from its own address. Stray memory requests from branch or unused codes show up when the count of accepted requests is compared with the number of indexed operations issued.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        MD_SEQ    = 3'd0,
        MD_REL    = 3'd1,
        MD_ABS    = 3'd2,
        MD_LONG   = 3'd3,
        MD_IDX_DP = 3'd4,
        MD_IDX_PC = 3'd5,
        MD_RSV6   = 3'd6,
        MD_RSV7   = 3'd7
    } cfa_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RSP  = 2'd2
    } cfa_state_e;

endpackage

// File: rtl/cfa_tgt_calc.sv
module cfa_tgt_calc
    import cfa_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int DW     = BYTE_W,
    parameter int PAGE_W = 11
) (
    input  logic [2:0]    mode,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] next_pc,
    input  logic [DW-1:0] acc,
    input  logic [AW-1:0] dptr,
    input  logic [DW-1:0] op1,
    input  logic [DW-1:0] op2,
    output logic [AW-1:0] branch_addr,
    output logic [AW-1:0] fetch_addr,
    output logic          is_idx
);

    localparam int EXT_W = AW - DW;
    localparam int OPH_W = PAGE_W - DW;

    logic [AW-1:0] rel_sum;
    logic [AW-1:0] abs_splice;
    logic [AW-1:0] long_join;
    logic [AW-1:0] idx_base;

    // signed offset applied to the jump's own address; wraps naturally
    assign rel_sum    = cur_pc + {{EXT_W{op1[DW-1]}}, op1};
    // page bits from the following instruction, low bits from the operand
    assign abs_splice = {next_pc[AW-1:PAGE_W], op1[OPH_W-1:0], op2};
    assign long_join  = {op1, op2};

    always_comb begin
        branch_addr = next_pc;
        idx_base    = dptr;
        is_idx      = 1'b0;
        unique case (cfa_mode_e'(mode))
            MD_REL:    branch_addr = rel_sum;
            MD_ABS:    branch_addr = abs_splice;
            MD_LONG:   branch_addr = long_join;
            MD_IDX_DP: begin
                idx_base = dptr;
                is_idx   = 1'b1;
            end
            MD_IDX_PC: begin
                idx_base = next_pc;
                is_idx   = 1'b1;
            end
            MD_SEQ, MD_RSV6, MD_RSV7: branch_addr = next_pc;
        endcase
    end

    // accumulator is an unsigned index
    assign fetch_addr = idx_base + {{EXT_W{1'b0}}, acc};

endmodule

// File: rtl/cfa_idx_fsm.sv
module cfa_idx_fsm
    import cfa_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_idx,
    input  logic [AW-1:0] fetch_addr,
    output logic          idle,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          mem_rsp_ready,
    output logic          acc_we,
    output logic [DW-1:0] acc_wdata
);

    cfa_state_e state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          launch;

    assign launch = start && is_idx && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (launch) addr_q <= fetch_addr;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)        state_d = ST_REQ;
            ST_REQ:  if (mem_req_ready) state_d = ST_RSP;
            ST_RSP:  if (mem_rsp_valid) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle          = 1'b0;
        mem_req_valid = 1'b0;
        mem_rsp_ready = 1'b0;
        acc_we        = 1'b0;
        unique case (state_q)
            ST_IDLE: idle          = 1'b1;
            ST_REQ:  mem_req_valid = 1'b1;
            ST_RSP: begin
                mem_rsp_ready = 1'b1;
                acc_we        = mem_rsp_valid;
            end
            default: idle          = 1'b0;
        endcase
    end

    assign mem_addr  = addr_q;
    assign acc_wdata = mem_rsp_data;

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

    a_r9_req_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(start));

    a_r10_wb_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> mem_rsp_valid && mem_rsp_ready);

    a_r10_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |=> idle);

endmodule

// File: rtl/cfa_addr_unit.sv
module cfa_addr_unit
    import cfa_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int DW      = BYTE_W,
    parameter int PAGE_W  = 11,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] next_pc,
    input  logic [DW-1:0] acc,
    input  logic [AW-1:0] dptr,
    input  logic [DW-1:0] op1,
    input  logic [DW-1:0] op2,
    output logic          tgt_valid,
    output logic [AW-1:0] tgt_addr,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          mem_rsp_ready,
    output logic          acc_we,
    output logic [DW-1:0] acc_wdata
);

    logic [AW-1:0] branch_addr;
    logic [AW-1:0] fetch_addr;
    logic          is_idx;
    logic          idle;
    logic          branch_fire;

    cfa_tgt_calc #(.AW(AW), .DW(DW), .PAGE_W(PAGE_W)) u_calc (
        .mode        (mode),
        .cur_pc      (cur_pc),
        .next_pc     (next_pc),
        .acc         (acc),
        .dptr        (dptr),
        .op1         (op1),
        .op2         (op2),
        .branch_addr (branch_addr),
        .fetch_addr  (fetch_addr),
        .is_idx      (is_idx)
    );

    cfa_idx_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .is_idx        (is_idx),
        .fetch_addr    (fetch_addr),
        .idle          (idle),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_addr      (mem_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_ready (mem_rsp_ready),
        .acc_we        (acc_we),
        .acc_wdata     (acc_wdata)
    );

    assign branch_fire = start && idle && !is_idx;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tgt_valid <= 1'b0;
                    tgt_addr  <= '0;
                end else begin
                    tgt_valid <= branch_fire;
                    if (branch_fire) tgt_addr <= branch_addr;
                end
            end

            a_r8_valid_from_start: assert property (@(posedge clk) disable iff (!rst_n)
                tgt_valid |-> $past(start));
        end else begin : g_comb
            assign tgt_valid = branch_fire;
            assign tgt_addr  = branch_addr;
        end
    endgenerate

    a_r7_no_wb_with_branch: assert property (@(posedge clk) disable iff (!rst_n)
        !(tgt_valid && acc_we));

    a_r11_no_req_with_branch: assert property (@(posedge clk) disable iff (!rst_n)
        !(tgt_valid && mem_req_valid));

endmodule

// File: tb/sim_cfa_addr_unit.sv
module sim_cfa_addr_unit;

    typedef struct {
        bit          is_wb;
        logic [15:0] val;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [15:0] cur_pc = '0, next_pc = '0, dptr = '0;
    logic [7:0]  acc = '0, op1 = '0, op2 = '0;
    logic        tgt_valid, mem_req_valid, mem_rsp_ready, acc_we;
    logic [15:0] tgt_addr, mem_addr;
    logic [7:0]  acc_wdata;
    logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;

    int nchk = 0, nerr = 0, nreq = 0, nidx = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    cfa_addr_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .cur_pc(cur_pc), .next_pc(next_pc), .acc(acc), .dptr(dptr),
        .op1(op1), .op2(op2), .tgt_valid(tgt_valid), .tgt_addr(tgt_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_ready(mem_rsp_ready),
        .acc_we(acc_we), .acc_wdata(acc_wdata)
    );

    function automatic logic [7:0] code_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as results appear
    task automatic take(input bit wb, input logic [15:0] v);
        exp_t e;
        if (sb.size() == 0) begin
            chk(1'b0, wb ? "R11 unexpected write-back" : "R11 unexpected target", v, 16'hxxxx);
        end else begin
            e = sb.pop_front();
            chk(e.is_wb == wb && v == e.val, e.req, v, e.val);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk); #2;
            if (rst_n) begin
                if (tgt_valid) take(1'b0, tgt_addr);
                if (acc_we)    take(1'b1, {8'h00, acc_wdata});
            end
        end
    end

    // program memory model with varying latency
    initial begin
        logic [15:0] a;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                repeat (nreq % 3) @(negedge clk);
                mem_req_ready = 1'b1;
                a = mem_addr;
                @(negedge clk);
                mem_req_ready = 1'b0;
                nreq++;
                repeat ((nreq + 1) % 2) @(negedge clk);
                mem_rsp_data  = code_byte(a);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic setup(input logic [2:0] m, input logic [15:0] c, input logic [15:0] n,
                         input logic [7:0] a, input logic [15:0] d, input logic [7:0] o1, input logic [7:0] o2);
        mode = m; cur_pc = c; next_pc = n; acc = a; dptr = d; op1 = o1; op2 = o2;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic branch_op(input logic [2:0] m, input logic [15:0] c, input logic [15:0] n,
                             input logic [7:0] o1, input logic [7:0] o2, input logic [15:0] expv, input string req);
        exp_t e;
        @(negedge clk);
        setup(m, c, n, 8'h77, 16'h2222, o1, o2);
        start = 1'b1;
        e.is_wb = 1'b0; e.val = expv; e.req = req;
        sb.push_back(e);
        @(negedge clk); start = 1'b0; #1;
        chk(tgt_valid == 1'b1, "R8 valid one cycle after start", {15'd0, tgt_valid}, 16'd1);
        chk(mem_req_valid == 1'b0, "R7 no memory request for branch", {15'd0, mem_req_valid}, 16'd0);
        @(negedge clk); #1;
        chk(tgt_valid == 1'b0, "R8 valid lasts one cycle", {15'd0, tgt_valid}, 16'd0);
        drain();
    endtask

    task automatic idx_op(input logic [2:0] m, input logic [15:0] n, input logic [7:0] a,
                          input logic [15:0] d, input logic [15:0] faddr, input string req, input bit poke);
        exp_t e;
        @(negedge clk);
        setup(m, 16'h0BAD, n, a, d, 8'h12, 8'h34);
        start = 1'b1;
        nidx++;
        e.is_wb = 1'b1; e.val = {8'h00, code_byte(faddr)}; e.req = req;
        sb.push_back(e);
        @(negedge clk); start = 1'b0; #1;
        chk(mem_req_valid == 1'b1, "R9 request the cycle after start", {15'd0, mem_req_valid}, 16'd1);
        chk(mem_addr == faddr, req, mem_addr, faddr);
        if (poke) begin
            // R11: a long-jump start while the read is busy must be ignored
            setup(3'b011, 16'h0, 16'h0, 8'h0, 16'h0, 8'hAB, 8'hCD);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        drain();
        @(negedge clk); #1;
        chk(acc_we == 1'b0 && mem_rsp_ready == 1'b0, "R10 back to idle after write-back",
            {14'd0, acc_we, mem_rsp_ready}, 16'd0);
    endtask

    initial begin
        #(8 * 100000);
        nerr++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!tgt_valid && !mem_req_valid && !mem_rsp_ready && !acc_we, "R1 reset outputs",
            {12'd0, tgt_valid, mem_req_valid, mem_rsp_ready, acc_we}, 16'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2 relative
        branch_op(3'b001, 16'h1000, 16'h1002, 8'h34, 8'h00, 16'h1034, "R2 relative forward");
        branch_op(3'b001, 16'h0005, 16'h0007, 8'hF0, 8'h00, 16'hFFF5, "R2 relative backward wrap");
        branch_op(3'b001, 16'hFFF0, 16'hFFF2, 8'h20, 8'h00, 16'h0010, "R2 relative forward wrap");
        // R3 absolute
        branch_op(3'b010, 16'h3FFE, 16'h4000, 8'h05, 8'h00, 16'h4500, "R3 page-absolute");
        branch_op(3'b010, 16'hF7FE, 16'hF800, 8'hFF, 8'hFF, 16'hFFFF, "R3 page-absolute top");
        // R4 long
        branch_op(3'b011, 16'h1234, 16'h1237, 8'h05, 8'h00, 16'h0500, "R4 long");
        branch_op(3'b011, 16'h0000, 16'h0003, 8'hA5, 8'h3C, 16'hA53C, "R4 long byte order");
        // R7 unused codes
        branch_op(3'b000, 16'h2000, 16'h2001, 8'h55, 8'h66, 16'h2001, "R7 code 0 gives next");
        branch_op(3'b110, 16'h2000, 16'h2003, 8'h55, 8'h66, 16'h2003, "R7 code 6 gives next");
        branch_op(3'b111, 16'hABCD, 16'hABCE, 8'h55, 8'h66, 16'hABCE, "R7 code 7 gives next");

        // R5 / R6 indexed, with R9 / R10 handshakes
        idx_op(3'b100, 16'h0000, 8'h10, 16'h3000, 16'h3010, "R5 dptr index", 1'b0);
        idx_op(3'b100, 16'h0000, 8'h20, 16'hFFF0, 16'h0010, "R5 dptr index wrap", 1'b0);
        idx_op(3'b100, 16'h0000, 8'hFF, 16'h0100, 16'h01FF, "R5 acc unsigned", 1'b0);
        idx_op(3'b101, 16'h4321, 8'h80, 16'h9999, 16'h43A1, "R6 pc index", 1'b0);
        idx_op(3'b101, 16'hFFFF, 8'h02, 16'h9999, 16'h0001, "R6 pc index wrap", 1'b1);

        // R11 a branch still works after the busy period
        branch_op(3'b011, 16'h0000, 16'h0003, 8'h12, 8'h34, 16'h1234, "R11 branch after busy");

        repeat (4) @(negedge clk);
        chk(nreq == nidx, "R7 R11 request count", nreq[15:0], nidx[15:0]);
        chk(sb.size() == 0, "R10 scoreboard drained", sb.size(), 16'd0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule